// File: doc/BRIEF.md
# Instruction Cycle Control Sequencer

This block is the step controller of a small 16-bit accumulator machine. A step counter runs through sixteen decoded timing strobes. The first three steps fetch an instruction word from memory and latch it. Every memory access goes through a 12-bit address register, and a 12-bit program counter supplies the fetch address. In the fourth step the instruction is sorted into one of four groups:

- memory operand, direct;
- memory operand, indirect;
- accumulator operation;
- input/output operation.

For the indirect group, the block replaces the address register with the pointer word read from memory.

The datapath and the execute logic around the block use its timing strobes, its decoded opcode lines and its group enables. When an instruction has finished, the execute logic raises a clear request and the next fetch begins at step 0. The accumulator and input/output groups finish inside step 3, so the sequencer clears its own counter for them.

Top module: `ctl_sequencer`

## Requirements
- R1: While `rst_ni` is low, `t_o` equals 1 (step 0), `pc_o` equals `RESET_PC` (0 by default), `mem_addr_o` is 0, `ir_o` is 0 and `i_o` is 0.
- R2: Each clock without a clear moves the step counter up by one, and `t_o` is one-hot with bit n high at step n. After step 15 the next step is step 0.
- R3: In step 0 `ar_ld_o` is high, and the address register takes the program counter value at the end of that step.
- R4: In step 1 `mem_rd_o`, `ir_ld_o` and `pc_inc_o` are high and `mem_addr_o` holds the fetch address. At the end of step 1, `ir_o` takes `mem_rdata_i` and `pc_o` increases by one.
- R5: At the end of step 2 the address register takes `ir_o[11:0]` and `i_o` takes `ir_o[15]`. `d_o` is one-hot with bit k high when `ir_o[14:12]` equals k.
- R6: In step 3, for an opcode other than 7, one of two enables is high, and the address register handles the pointer as follows:
  - With `i_o`=1, `mr_ind_o` and `mem_rd_o` are high, and the address register takes `mem_rdata_i[11:0]`.
  - With `i_o`=0, `mr_dir_o` is high, there is no read, and the address register is unchanged.
- R7: For opcode 7 with bit 15 = 0, `rr_en_o` is high for exactly step 3 and the next step is step 0. Bit 15 does not trigger an indirect read here.
- R8: For opcode 7 with bit 15 = 1, `io_en_o` is high for exactly step 3 and the next step is step 0.
- R9: For an opcode other than 7, the counter is not cleared after step 3, so step 4 follows.
- R10: `sc_clr_i` high forces step 0 on the next clock in any step. The clear takes priority over counting, but the other strobes of that step still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| mem_rdata_i | input | 16 | word read from memory at `mem_addr_o` |
| sc_clr_i | input | 1 | clear request from the execute logic |
| t_o | output | 16 | one-hot timing strobes, bit n = step n |
| d_o | output | 8 | one-hot decoded opcode |
| ir_o | output | 16 | latched instruction word |
| i_o | output | 1 | latched bit 15 of the instruction |
| pc_o | output | 12 | program counter |
| mem_addr_o | output | 12 | memory address (address register) |
| mem_rd_o | output | 1 | memory read strobe |
| ar_ld_o | output | 1 | address register load strobe |
| ir_ld_o | output | 1 | instruction register load strobe |
| pc_inc_o | output | 1 | program counter increment strobe |
| mr_dir_o | output | 1 | step 3 enable, direct memory-operand instruction |
| mr_ind_o | output | 1 | step 3 enable, indirect memory-operand instruction |
| rr_en_o | output | 1 | step 3 enable, accumulator operation |
| io_en_o | output | 1 | step 3 enable, input/output operation |

## Verification
A wrong step count shows at `t_o` on the very next clock, and it shifts every strobe after it. A bad address register or program counter shows at `mem_addr_o` in the next step 1 or step 3, where the read uses the wrong word. A bad latched `i_o` or opcode shows in step 3 as the wrong group enable, or as a missing or extra indirect read. If it goes unnoticed, it surfaces one cycle later as a step 0 or step 4 that should not occur. The bench follows four instruction groups, a counter wrap and an early clear through those windows.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

  typedef enum logic [1:0] {
    CLS_MEM_DIR = 2'd0,
    CLS_MEM_IND = 2'd1,
    CLS_REG     = 2'd2,
    CLS_IO      = 2'd3
  } instr_cls_e;

  // opc_max: opcode field is all ones; mode: top instruction bit
  function automatic instr_cls_e classify(input logic opc_max, input logic mode);
    if (!opc_max) return mode ? CLS_MEM_IND : CLS_MEM_DIR;
    return mode ? CLS_IO : CLS_REG;
  endfunction

endpackage

// File: rtl/seq_counter.sv
module seq_counter #(
  parameter int SC_W  = 4,
  localparam int NUM_T = 1 << SC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [NUM_T-1:0] t_o
);

  logic [SC_W-1:0] sc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sc_q <= '0;
    else if (clr_i) sc_q <= '0;
    else            sc_q <= sc_q + SC_W'(1);
  end

  for (genvar k = 0; k < NUM_T; k++) begin : g_tdec
    assign t_o[k] = (sc_q == SC_W'(k));
  end

  a_r2_count_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> sc_q == $past(sc_q) + SC_W'(1));

  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> t_o[0]);

endmodule

// File: rtl/op_decoder.sv
module op_decoder #(
  parameter int OPC_W = 3,
  localparam int NUM_D = 1 << OPC_W
) (
  input  logic [OPC_W-1:0] opc_i,
  output logic [NUM_D-1:0] d_o
);

  for (genvar k = 0; k < NUM_D; k++) begin : g_ddec
    assign d_o[k] = (opc_i == OPC_W'(k));
  end

endmodule

// File: rtl/fetch_path.sv
module fetch_path #(
  parameter int          DATA_W   = 16,
  parameter int          ADDR_W   = 12,
  parameter logic [11:0] RESET_PC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              ar_from_pc_i,
  input  logic              ar_from_ir_i,
  input  logic              ar_from_mem_i,
  input  logic              ir_ld_i,
  input  logic              pc_inc_i,
  output logic [ADDR_W-1:0] ar_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] ir_o,
  output logic              i_o
);

  logic [ADDR_W-1:0] ar_q, pc_q;
  logic [DATA_W-1:0] ir_q;
  logic              i_q;

  // address register: one source per step, steps are exclusive
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            ar_q <= '0;
    else if (ar_from_pc_i)  ar_q <= pc_q;
    else if (ar_from_ir_i)  ar_q <= ir_q[ADDR_W-1:0];
    else if (ar_from_mem_i) ar_q <= mem_rdata_i[ADDR_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pc_q <= RESET_PC[ADDR_W-1:0];
    else if (pc_inc_i) pc_q <= pc_q + ADDR_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ir_q <= '0;
    else if (ir_ld_i)  ir_q <= mem_rdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           i_q <= 1'b0;
    else if (ar_from_ir_i) i_q <= ir_q[DATA_W-1];
  end

  assign ar_o = ar_q;
  assign pc_o = pc_q;
  assign ir_o = ir_q;
  assign i_o  = i_q;

  a_r3_ar_from_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_from_pc_i |=> ar_q == $past(pc_q));

  a_r4_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_inc_i |=> pc_q == $past(pc_q) + ADDR_W'(1));

  a_r4_ir_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_ld_i |=> ir_q == $past(mem_rdata_i));

  a_r5_ar_from_ir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_from_ir_i |=> (ar_q == $past(ir_q[ADDR_W-1:0])) && (i_q == $past(ir_q[DATA_W-1])));

  a_r6_ar_from_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_from_mem_i |=> ar_q == $past(mem_rdata_i[ADDR_W-1:0]));

endmodule

// File: rtl/ctl_sequencer.sv
module ctl_sequencer #(
  parameter int          DATA_W   = 16,
  parameter int          ADDR_W   = 12,
  parameter int          OPC_W    = 3,
  parameter int          SC_W     = 4,
  parameter logic [11:0] RESET_PC = '0,
  localparam int NUM_T   = 1 << SC_W,
  localparam int NUM_D   = 1 << OPC_W,
  localparam int MODE_B  = DATA_W - 1,
  localparam int OPC_LSB = ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              sc_clr_i,
  output logic [NUM_T-1:0]  t_o,
  output logic [NUM_D-1:0]  d_o,
  output logic [DATA_W-1:0] ir_o,
  output logic              i_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              ar_ld_o,
  output logic              ir_ld_o,
  output logic              pc_inc_o,
  output logic              mr_dir_o,
  output logic              mr_ind_o,
  output logic              rr_en_o,
  output logic              io_en_o
);
  import ctl_pkg::*;

  logic [NUM_T-1:0] t;
  logic [NUM_D-1:0] d;
  logic [DATA_W-1:0] ir;
  logic             mode;
  logic             sc_clr;
  instr_cls_e       cls;

  seq_counter #(.SC_W(SC_W)) u_sc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (sc_clr),
    .t_o    (t)
  );

  op_decoder #(.OPC_W(OPC_W)) u_dec (
    .opc_i (ir[OPC_LSB +: OPC_W]),
    .d_o   (d)
  );

  fetch_path #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_fetch (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .mem_rdata_i   (mem_rdata_i),
    .ar_from_pc_i  (t[0]),
    .ar_from_ir_i  (t[2]),
    .ar_from_mem_i (mr_ind_o),
    .ir_ld_i       (t[1]),
    .pc_inc_i      (t[1]),
    .ar_o          (mem_addr_o),
    .pc_o          (pc_o),
    .ir_o          (ir),
    .i_o           (mode)
  );

  // group is judged on the latched mode bit, valid from step 3 on
  assign cls = classify(d[NUM_D-1], mode);

  always_comb begin
    mr_dir_o = t[3] && (cls == CLS_MEM_DIR);
    mr_ind_o = t[3] && (cls == CLS_MEM_IND);
    rr_en_o  = t[3] && (cls == CLS_REG);
    io_en_o  = t[3] && (cls == CLS_IO);
  end

  assign sc_clr   = sc_clr_i | rr_en_o | io_en_o;
  assign ar_ld_o  = t[0] | t[2] | mr_ind_o;
  assign ir_ld_o  = t[1];
  assign pc_inc_o = t[1];
  assign mem_rd_o = t[1] | mr_ind_o;

  assign t_o  = t;
  assign d_o  = d;
  assign ir_o = ir;
  assign i_o  = mode;

  initial begin
    a_r5_fields_fit: assert (ADDR_W + OPC_W + 1 == DATA_W);
  end

  a_r2_t_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(t_o));

  a_r6_one_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mr_dir_o, mr_ind_o, rr_en_o, io_en_o}));

  a_r6_dir_keeps_ar: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mr_dir_o && !sc_clr_i) |=> $stable(mem_addr_o));

  a_r7_rr_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rr_en_o |=> t_o[0] && !rr_en_o);

  a_r8_io_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_en_o |=> t_o[0] && !io_en_o);

  a_r9_mem_continues: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mr_dir_o || mr_ind_o) && !sc_clr_i) |=> t_o[4]);

endmodule

// File: tb/tb_ctl_sequencer.sv
module tb_ctl_sequencer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sc_clr_i = 1'b0;
  logic [15:0] mem_rdata;
  logic [15:0] t_o, ir_o;
  logic [7:0]  d_o;
  logic [11:0] pc_o, mem_addr_o;
  logic        i_o, mem_rd_o, ar_ld_o, ir_ld_o, pc_inc_o;
  logic        mr_dir_o, mr_ind_o, rr_en_o, io_en_o;
  logic [15:0] mem [0:4095];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign mem_rdata = mem[mem_addr_o];

  ctl_sequencer dut (
    .clk_i(clk), .rst_ni(rst_ni), .mem_rdata_i(mem_rdata), .sc_clr_i(sc_clr_i),
    .t_o(t_o), .d_o(d_o), .ir_o(ir_o), .i_o(i_o), .pc_o(pc_o),
    .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .ar_ld_o(ar_ld_o),
    .ir_ld_o(ir_ld_o), .pc_inc_o(pc_inc_o), .mr_dir_o(mr_dir_o),
    .mr_ind_o(mr_ind_o), .rr_en_o(rr_en_o), .io_en_o(io_en_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  // fetch steps 0..2 from address a, expecting word w
  task automatic fetch(input logic [11:0] a, input logic [15:0] w);
    chk("R3 step0 t", t_o, 16'h0001);
    chk("R3 ar_ld", ar_ld_o, 1);
    tick();
    chk("R3 ar=pc", mem_addr_o, a);
    chk("R4 rd/ld/inc", {mem_rd_o, ir_ld_o, pc_inc_o}, 3'b111);
    tick();
    chk("R4 ir", ir_o, w);
    chk("R4 pc+1", pc_o, a + 12'd1);
    chk("R5 d onehot", d_o, 8'h01 << w[14:12]);
    chk("R2 step2", t_o, 16'h0004);
    tick();
    chk("R5 ar=ir", mem_addr_o, w[11:0]);
    chk("R5 i bit", i_o, w[15]);
  endtask

  task automatic t_reset();
    tick(); tick();
    chk("R1 t", t_o, 16'h0001);
    chk("R1 pc", pc_o, 0);
    chk("R1 ar", mem_addr_o, 0);
    chk("R1 ir", ir_o, 0);
    chk("R1 i", i_o, 0);
    rst_ni = 1'b1;
    #1;
  endtask

  task automatic t_reg_op();
    fetch(12'h000, 16'h7800);
    chk("R7 rr_en", {rr_en_o, io_en_o, mr_dir_o, mr_ind_o}, 4'b1000);
    chk("R7 no ind read", mem_rd_o, 0);
    tick();
    chk("R7 back to step0", t_o, 16'h0001);
    chk("R7 rr one cycle", rr_en_o, 0);
  endtask

  task automatic t_io_op();
    fetch(12'h001, 16'hF400);
    chk("R8 io_en", {rr_en_o, io_en_o, mr_dir_o, mr_ind_o}, 4'b0100);
    chk("R8 no read", mem_rd_o, 0);
    tick();
    chk("R8 back to step0", t_o, 16'h0001);
  endtask

  task automatic t_indirect();
    fetch(12'h002, 16'h9123);
    chk("R6 ind enable", {rr_en_o, io_en_o, mr_dir_o, mr_ind_o}, 4'b0001);
    chk("R6 ind read", mem_rd_o, 1);
    tick();
    chk("R9 step4", t_o, 16'h0010);
    chk("R6 ar=pointer", mem_addr_o, 12'h456);
    tick();
    chk("R2 step5", t_o, 16'h0020);
    sc_clr_i = 1'b1;
    tick();
    sc_clr_i = 1'b0;
    chk("R10 clear to step0", t_o, 16'h0001);
    chk("R10 pc held", pc_o, 12'h003);
  endtask

  task automatic t_direct_wrap();
    fetch(12'h003, 16'h2055);
    chk("R6 dir enable", {rr_en_o, io_en_o, mr_dir_o, mr_ind_o}, 4'b0010);
    chk("R6 dir no read", mem_rd_o, 0);
    tick();
    chk("R9 step4", t_o, 16'h0010);
    chk("R6 ar kept", mem_addr_o, 12'h055);
    for (int k = 5; k <= 15; k++) tick();
    chk("R2 step15", t_o, 16'h8000);
    tick();
    chk("R2 wrap to step0", t_o, 16'h0001);
  endtask

  task automatic t_early_clear();
    chk("R10 pre step0", t_o, 16'h0001);
    tick();
    chk("R10 in step1", t_o, 16'h0002);
    sc_clr_i = 1'b1;
    tick();
    sc_clr_i = 1'b0;
    chk("R10 step0 after clear", t_o, 16'h0001);
    chk("R10 step1 strobes kept pc", pc_o, 12'h005);
    chk("R10 step1 strobes kept ir", ir_o, 16'h7800);
  endtask

  initial begin
    for (int a = 0; a < 4096; a++) mem[a] = 16'h0000;
    mem[12'h000] = 16'h7800;
    mem[12'h001] = 16'hF400;
    mem[12'h002] = 16'h9123;
    mem[12'h123] = 16'h0456;
    mem[12'h003] = 16'h2055;
    mem[12'h004] = 16'h7800;
    t_reset();
    t_reg_op();
    t_io_op();
    t_indirect();
    t_direct_wrap();
    t_early_clear();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule